// File: doc/BRIEF.md
# Branch Squash and Redirect Control

This block steers the fetch address of a five-stage in-order pipeline that treats every conditional branch as not taken. Fetch keeps stepping one instruction at a time past a branch, and no bubble is inserted when a branch is decoded. In Execute, a small arithmetic unit inside the block works out the branch destination and compares the two source operands. The surrounding EX/Mem pipeline register carries both results forward.

When the branch sits in the Memory stage, the block decides. If the opcode there is a valid branch and its equality flag is set, the branch is taken. In that case the block selects the carried target for the PC and raises one squash enable for each of the three younger stage registers: IF/ID, ID/EX and EX/Mem. Each of those registers loads a noop at the next edge, so the squashed instructions never write registers or memory and never retire. A taken branch therefore costs exactly three slots, and a not-taken branch costs nothing. A redirect also wins over a load-use stall request raised in the same cycle.

Top module: `br_redirect_ctrl`

## Requirements
- R1: While `rst_n` is low, `pc` is `RESET_PC` (0 by default), and `pc_sel` and all three squash enables are 0 when the Memory-stage inputs are idle.
- R2: With no taken branch and no stall, `pc` advances by exactly one at each rising edge and wraps from all-ones to zero.
- R3: With no taken branch and `stall_req` high, `pc` keeps its value across the edge.
- R4: A branch is taken when `mem_valid` is 1, `mem_op` equals the branch code `BR_OP` (3'b100 by default) and `mem_equal` is 1. In that cycle `pc_sel` is 1, and after the next edge `pc` equals `mem_target`.
- R5: `squash_ifid`, `squash_idex` and `squash_exmem` are all 1 in the cycle a branch is taken and all 0 in every other cycle, so a taken branch removes exactly three younger instructions.
- R6: A valid branch whose `mem_equal` is 0 causes no squash and no redirect. A valid non-branch opcode causes neither, whatever `mem_equal` holds. In both cases `pc` advances by one.
- R7: When a branch is taken and `stall_req` is high in the same cycle, `pc` still loads `mem_target` and all three squash enables are 1.
- R8: When `mem_valid` is 0, the Memory-stage inputs are ignored: `pc_sel` and the squash enables are 0, and `pc` advances by one (or holds under stall), even with a branch opcode and `mem_equal` set.
- R9: `ex_target` equals `ex_pc + 1 + sign-extended ex_offset`, modulo 2^`PC_W`.
- R10: `ex_equal` is 1 exactly when `ex_rega` equals `ex_regb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ex_pc | input | PC_W | Address of the branch in Execute |
| ex_offset | input | OFF_W | Signed branch displacement in Execute |
| ex_rega | input | DATA_W | First source operand in Execute |
| ex_regb | input | DATA_W | Second source operand in Execute |
| ex_target | output | PC_W | Computed branch destination |
| ex_equal | output | 1 | Operand equality result |
| mem_valid | input | 1 | Memory-stage slot holds a live instruction |
| mem_op | input | OP_W | Opcode in the Memory stage |
| mem_equal | input | 1 | Carried equality flag in the Memory stage |
| mem_target | input | PC_W | Carried branch destination in the Memory stage |
| stall_req | input | 1 | Load-use stall request: hold the PC |
| pc_sel | output | 1 | 1 selects the branch target as the next PC |
| pc | output | PC_W | Current fetch address |
| squash_ifid | output | 1 | Load a noop into IF/ID at the next edge |
| squash_idex | output | 1 | Load a noop into ID/EX at the next edge |
| squash_exmem | output | 1 | Load a noop into EX/Mem at the next edge |

## Verification
Two events can fall in the same cycle: a taken-branch redirect and a load-use stall request. The stimulus table contains a row where a taken branch meets a high `stall_req`, and a later row where the stall appears alone. The first row is judged correct only if the PC loads the target and all three squash enables rise. The second row is judged correct only if the PC holds. A redirect to the all-ones address, followed by an idle cycle, also checks that the sequential step wraps to zero.

// File: rtl/br_pkg.sv
package br_pkg;
  // Source of the next fetch address, in priority order: target, hold, step.
  typedef enum logic [1:0] {
    PC_SEQ    = 2'd0,
    PC_HOLD   = 2'd1,
    PC_TARGET = 2'd2
  } pc_src_e;
endpackage

// File: rtl/br_target_unit.sv
module br_target_unit #(
  parameter int PC_W   = 16,
  parameter int OFF_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic [PC_W-1:0]   pc_in,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [PC_W-1:0]   target,
  output logic              equal
);
  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  function automatic logic [PC_W-1:0] sext(input logic [OFF_W-1:0] v);
    return PC_W'($signed(v));
  endfunction

  function automatic logic [PC_W-1:0] dest(input logic [PC_W-1:0] p,
                                           input logic [OFF_W-1:0] o);
    return p + ONE + sext(o);
  endfunction

  assign target = dest(pc_in, offset);
  assign equal  = (opa == opb);
endmodule

// File: rtl/br_resolve.sv
module br_resolve
  import br_pkg::*;
#(
  parameter int              OP_W  = 3,
  parameter logic [OP_W-1:0] BR_OP = 3'b100
) (
  input  logic            valid,
  input  logic [OP_W-1:0] op,
  input  logic            eq,
  input  logic            stall,
  output logic            taken,
  output pc_src_e         src
);
  logic is_branch;

  assign is_branch = valid && (op == BR_OP);
  assign taken     = is_branch && eq;

  always_comb begin
    if (taken)      src = PC_TARGET;
    else if (stall) src = PC_HOLD;
    else            src = PC_SEQ;
  end
endmodule

// File: rtl/br_pc_reg.sv
module br_pc_reg
  import br_pkg::*;
#(
  parameter int              PC_W     = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  pc_src_e         src,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= RESET_PC;
    else begin
      case (src)
        PC_TARGET: pc <= target;
        PC_HOLD:   pc <= pc;
        default:   pc <= pc + STEP;
      endcase
    end
  end
endmodule

// File: rtl/br_redirect_ctrl.sv
module br_redirect_ctrl
  import br_pkg::*;
#(
  parameter int              PC_W     = 16,
  parameter int              OFF_W    = 16,
  parameter int              DATA_W   = 32,
  parameter int              OP_W     = 3,
  parameter logic [OP_W-1:0] BR_OP    = 3'b100,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   ex_pc,
  input  logic [OFF_W-1:0]  ex_offset,
  input  logic [DATA_W-1:0] ex_rega,
  input  logic [DATA_W-1:0] ex_regb,
  output logic [PC_W-1:0]   ex_target,
  output logic              ex_equal,
  input  logic              mem_valid,
  input  logic [OP_W-1:0]   mem_op,
  input  logic              mem_equal,
  input  logic [PC_W-1:0]   mem_target,
  input  logic              stall_req,
  output logic              pc_sel,
  output logic [PC_W-1:0]   pc,
  output logic              squash_ifid,
  output logic              squash_idex,
  output logic              squash_exmem
);
  localparam int N_SQ = 3;

  logic    br_taken;
  pc_src_e pc_src;
  logic [N_SQ-1:0] sq_vec;

  br_target_unit #(.PC_W(PC_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) i_tgt (
    .pc_in(ex_pc), .offset(ex_offset), .opa(ex_rega), .opb(ex_regb),
    .target(ex_target), .equal(ex_equal)
  );

  br_resolve #(.OP_W(OP_W), .BR_OP(BR_OP)) i_res (
    .valid(mem_valid), .op(mem_op), .eq(mem_equal), .stall(stall_req),
    .taken(br_taken), .src(pc_src)
  );

  br_pc_reg #(.PC_W(PC_W), .RESET_PC(RESET_PC)) i_pc (
    .clk(clk), .rst_n(rst_n), .src(pc_src), .target(mem_target), .pc(pc)
  );

  // One squash enable per younger stage register.
  for (genvar g = 0; g < N_SQ; g++) begin : g_sq
    assign sq_vec[g] = br_taken;
  end

  assign pc_sel       = (pc_src == PC_TARGET);
  assign squash_ifid  = sq_vec[0];
  assign squash_idex  = sq_vec[1];
  assign squash_exmem = sq_vec[2];
endmodule

// File: rtl/br_redirect_checker.sv
module br_redirect_checker #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_valid,
  input logic [PC_W-1:0] mem_target,
  input logic            stall_req,
  input logic            pc_sel,
  input logic [PC_W-1:0] pc,
  input logic            squash_ifid,
  input logic            squash_idex,
  input logic            squash_exmem
);
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_sel && !stall_req) |=> (pc == PC_W'($past(pc) + 1'b1)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_sel && stall_req) |=> $stable(pc));

  assert_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel |=> (pc == $past(mem_target)));

  assert_squash_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({squash_ifid, squash_idex, squash_exmem}) == (pc_sel ? 3 : 0)));

  assert_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_sel && stall_req) |=> (pc == $past(mem_target)));

  assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid |-> !pc_sel);
endmodule

bind br_redirect_ctrl br_redirect_checker #(.PC_W(PC_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_target(mem_target),
  .stall_req(stall_req), .pc_sel(pc_sel), .pc(pc), .squash_ifid(squash_ifid),
  .squash_idex(squash_idex), .squash_exmem(squash_exmem)
);

// File: tb/test_br_redirect_ctrl.sv
module test_br_redirect_ctrl;
  localparam int PERIOD = 10;
  localparam int PC_W = 16, OFF_W = 16, DATA_W = 32, OP_W = 3;
  localparam int NV = 12;
  // {valid, op[2:0], eq, stall, target[15:0], expected_taken}
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 3'b000, 1'b0, 1'b0, 16'h0000, 1'b0},
    {1'b0, 3'b000, 1'b0, 1'b0, 16'h0000, 1'b0},
    {1'b0, 3'b000, 1'b0, 1'b1, 16'h0000, 1'b0},
    {1'b1, 3'b100, 1'b0, 1'b0, 16'h0099, 1'b0},
    {1'b1, 3'b000, 1'b1, 1'b0, 16'h0077, 1'b0},
    {1'b0, 3'b100, 1'b1, 1'b0, 16'h0055, 1'b0},
    {1'b1, 3'b100, 1'b1, 1'b0, 16'h0040, 1'b1},
    {1'b0, 3'b000, 1'b0, 1'b0, 16'h0000, 1'b0},
    {1'b1, 3'b100, 1'b1, 1'b1, 16'h1234, 1'b1},
    {1'b0, 3'b000, 1'b0, 1'b1, 16'h0000, 1'b0},
    {1'b1, 3'b100, 1'b1, 1'b0, 16'hFFFF, 1'b1},
    {1'b0, 3'b000, 1'b0, 1'b0, 16'h0000, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] ex_pc = '0, ex_target, mem_target = '0, pc;
  logic [OFF_W-1:0] ex_offset = '0;
  logic [DATA_W-1:0] ex_rega = '0, ex_regb = '0;
  logic ex_equal, mem_valid = 0, mem_equal = 0, stall_req = 0;
  logic [OP_W-1:0] mem_op = '0;
  logic pc_sel, squash_ifid, squash_idex, squash_exmem;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [PC_W-1:0] model_pc;
  string prev_req;

  always #(PERIOD/2) clk = ~clk;

  br_redirect_ctrl i_br_redirect_ctrl (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pc", 32'(pc), 32'h0);
    chk("R1 pc_sel", 32'(pc_sel), 32'h0);
    chk("R1 squash", 32'({squash_ifid, squash_idex, squash_exmem}), 32'h0);
    rst_n = 1;
    model_pc = '0;
    prev_req = "R1";
    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      chk({prev_req, " pc"}, 32'(pc), 32'(model_pc));
      mem_valid = v[22]; mem_op = v[21:19]; mem_equal = v[18];
      stall_req = v[17]; mem_target = v[16:1];
      #1;
      chk("R4/R6/R8 pc_sel", 32'(pc_sel), 32'(v[0]));
      chk("R5 squash", 32'({squash_ifid, squash_idex, squash_exmem}), v[0] ? 32'h7 : 32'h0);
      if (v[0]) begin
        model_pc = v[16:1];
        prev_req = v[17] ? "R7" : "R4";
      end else if (v[17]) prev_req = "R3";
      else begin
        model_pc = model_pc + 1'b1;
        prev_req = "R2";
      end
      @(negedge clk);
    end
    chk({prev_req, " pc final"}, 32'(pc), 32'(model_pc));
    // Target arithmetic and equality
    ex_pc = 16'd10; ex_offset = 16'hFFFD; #1;
    chk("R9 negative offset", 32'(ex_target), 32'd8);
    ex_pc = 16'd10; ex_offset = 16'd5; #1;
    chk("R9 positive offset", 32'(ex_target), 32'd16);
    ex_pc = 16'hFFFF; ex_offset = 16'd0; #1;
    chk("R9 wrap", 32'(ex_target), 32'd0);
    ex_rega = 32'hDEAD_BEEF; ex_regb = 32'hDEAD_BEEF; #1;
    chk("R10 equal", 32'(ex_equal), 32'd1);
    ex_regb = 32'hDEAD_BEEE; #1;
    chk("R10 differ", 32'(ex_equal), 32'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule